// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core with seven operating modes. Software names sixteen registers, r0 to r15. The 3-bit mode input selects which physical word each name reaches. Some modes have private copies of the upper registers, and the remaining names fall through to a shared set. Storage is 37 words in total: 30 general-purpose words, one program counter, one current status word, and five saved status words, one for each exception mode.

The core reads two operands per cycle through combinational ports. It writes one result per cycle at the rising clock edge. All three ports are addressed by architectural index under the current mode. A separate port pair reads and writes the saved status word that belongs to the current mode. The current status word has its own write enable and is always visible at the output. Instruction decode, the ALU, program-counter arithmetic and exception entry sequencing all live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After the synchronous active-low reset, every general-purpose word, the program counter and every saved status word read zero. The current status output reads 32'h3, with bits [2:0] holding the supervisor mode code.
- R2: The mode codes are User=0, fast interrupt=1, interrupt=2, supervisor=3, abort=4, undefined=5 and System=6. Code 7 is reserved. Under User, System and code 7, indices r0 to r14 reach one common set of fifteen words.
- R3: Under code 1, indices r8 to r14 reach seven words private to that mode. Indices r0 to r7 reach the User words.
- R4: Under codes 2, 3, 4 and 5, indices r13 and r14 reach a pair of words private to each mode. Indices r0 to r12 reach the User words.
- R5: Index r15 reaches one program-counter word in every mode.
- R6: Under codes 1 to 5, the saved status read port returns that mode's own word. A write with the saved-status enable high updates only that word, at the clock edge.
- R7: Under codes 0, 6 and 7, the saved status read port returns zero, and a saved-status write changes no saved word.
- R8: A read of the word being written in the same cycle returns the old value. The new value appears after the clock edge.
- R9: The two read ports decode their indices independently and may address any two words at the same time.
- R10: With its enable high, the current status word takes the written value at the clock edge. With the enable low, the word holds.
- R11: With the write enable low, no general-purpose word or program-counter word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 3 | Current operating mode code |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | DATA_W | Register write data |
| cur_we | input | 1 | Current status write enable |
| cur_wdata | input | DATA_W | Current status write data |
| cur_st | output | DATA_W | Current status word |
| saved_we | input | 1 | Saved status write enable, current mode |
| saved_wdata | input | DATA_W | Saved status write data |
| saved_rdata | output | DATA_W | Saved status word of the current mode |

## Verification
The bench builds the block with the default 32-bit data width. At that width, random data tells every word apart. Each step of the run draws the mode from all eight codes, including the reserved one, so a word written under one mode is later read under every other mode. This brings crossings such as a fast-interrupt bank write followed by a User read, or writes to the two halves of one banked pair, within reach. Directed steps cover reads and writes in the same cycle, and saved-status writes issued under modes that have no saved word.

// File: rtl/bank_pkg.sv
// Package bank_pkg
// Mode codes and the mapping from (mode, architectural index) to a
// physical word slot. Assumes a 3-bit mode and a 4-bit index.
package bank_pkg;
    typedef enum logic [2:0] {
        M_USR = 3'd0, M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
        M_ABT = 3'd4, M_UND = 3'd5, M_SYS = 3'd6, M_RSV = 3'd7
    } mode_e;

    localparam int IDX_W    = 4;
    localparam int MODE_W   = 3;
    localparam int SHARED_N = 15;               // user r0..r14
    localparam int PC_SLOT  = 15;
    localparam int FAST_N   = 7;                // fast-interrupt private bank
    localparam int PAIR_N   = 4;                // modes with a private pair
    localparam int PHYS_N   = SHARED_N + 1 + FAST_N + 2 * PAIR_N;   // 31
    localparam int PHYS_W   = $clog2(PHYS_N);
    localparam int SAVED_N  = 5;
    localparam int SAVED_W  = $clog2(SAVED_N);

    // Physical slots: 0..14 shared, 15 pc, 16..22 fast bank,
    // 23..30 private pairs in mode-code order 2,3,4,5.
    function automatic logic [PHYS_W-1:0] phys_slot(logic [MODE_W-1:0] m,
                                                    logic [IDX_W-1:0]  idx);
        logic [2:0] pair;
        pair = m - 3'd2;
        if (idx == 4'd15)
            return PHYS_W'(PC_SLOT);
        if (m == M_FIQ && idx >= 4'd8)
            return 5'd16 + {2'b00, idx[2:0]};
        if ((m == M_IRQ || m == M_SVC || m == M_ABT || m == M_UND) && idx >= 4'd13)
            return 5'd23 + {1'b0, pair, 1'b0} + {4'b0000, ~idx[0]};
        return {1'b0, idx};
    endfunction

    function automatic logic has_saved(logic [MODE_W-1:0] m);
        return (m >= 3'd1) && (m <= 3'd5);
    endfunction
endpackage

// File: rtl/bank_map.sv
// Module bank_map
// Combinational translation of one architectural index into a physical
// slot under the given mode. Assumes mode codes from bank_pkg.
module bank_map
    import bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] slot
);
    // Translate index to slot
    always_comb slot = phys_slot(mode, idx);
endmodule

// File: rtl/gp_store.sv
// Module gp_store
// Flat array of general-purpose and program-counter words. It has NUM_RD
// combinational read ports and one write port that takes effect at the
// clock edge, so a read in the write cycle sees the old word.
// Assumes slots arrive already translated and in range.
module gp_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    parameter int NUM_RD = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_RD-1:0][AW-1:0]  raddr,
    output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store one word per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Asynchronous read of port p
        always_comb rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/status_store.sv
// Module status_store
// Current status word plus one saved status word per exception mode.
// The saved port addresses the current mode's word. Modes without a saved
// word read zero and drop writes. Assumes mode codes from bank_pkg.
module status_store
    import bank_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RESET_MODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] cur_st,
    input  logic              saved_we,
    input  logic [DATA_W-1:0] saved_wdata,
    output logic [DATA_W-1:0] saved_rdata
);
    logic [DATA_W-1:0]  saved_q [SAVED_N];
    logic [SAVED_W-1:0] sel;
    logic               valid;

    // Pick the saved word owned by the current mode
    always_comb begin
        valid = has_saved(mode);
        sel   = SAVED_W'(mode - 3'd1);
    end

    // Current status register with reset mode value
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_st <= DATA_W'(RESET_MODE);
        else if (cur_we) cur_st <= cur_wdata;
    end

    // Saved status words, written only in modes that own one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SAVED_N; i++) saved_q[i] <= '0;
        end else if (saved_we && valid) begin
            saved_q[sel] <= saved_wdata;
        end
    end

    // Saved read: zero when the mode has no saved word
    always_comb saved_rdata = valid ? saved_q[sel] : '0;
endmodule

// File: rtl/banked_regfile.sv
// Module banked_regfile
// Top of the mode-banked register file. Every architectural index
// goes through its own bank_map, then into gp_store. Status words live in
// status_store. Assumes the caller keeps mode steady for the whole cycle.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RESET_MODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] cur_st,
    input  logic              saved_we,
    input  logic [DATA_W-1:0] saved_wdata,
    output logic [DATA_W-1:0] saved_rdata
);
    localparam int NUM_RD = 2;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][PHYS_W-1:0] rd_slot;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
    logic [PHYS_W-1:0]             wr_slot;

    // Gather read indices and spread read data
    always_comb begin
        rd_idx[0] = rd_a_idx;
        rd_idx[1] = rd_b_idx;
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
        bank_map u_rmap (.mode(mode), .idx(rd_idx[p]), .slot(rd_slot[p]));
    end

    bank_map u_wmap (.mode(mode), .idx(wr_idx), .slot(wr_slot));

    gp_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N), .NUM_RD(NUM_RD)) u_gp (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_slot),
        .wdata(wr_data), .raddr(rd_slot), .rdata(rd_data)
    );

    status_store #(.DATA_W(DATA_W), .RESET_MODE(RESET_MODE)) u_st (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_st(cur_st),
        .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
// Module banked_regfile_chk
// Port-level properties of banked_regfile, attached by bind.
// Assumes synchronous active-low reset.
module banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              cur_we,
    input logic [DATA_W-1:0] cur_wdata,
    input logic [DATA_W-1:0] cur_st,
    input logic [DATA_W-1:0] saved_rdata
);
    // R7
    no_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode == 3'd6 || mode == 3'd7) |-> saved_rdata == '0);

    // R8
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $stable(mode) && rd_a_idx == $past(wr_idx))
        |-> rd_a_data == $past(wr_data));

    // R5
    pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_idx) == 4'd15 && rd_a_idx == 4'd15)
        |-> rd_a_data == $past(wr_data));

    // R10
    cur_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cur_we)) |-> cur_st == $past(cur_wdata));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(mode) && $stable(rd_a_idx))
        |-> $stable(rd_a_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_a_idx(rd_a_idx),
    .rd_a_data(rd_a_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_st(cur_st),
    .saved_rdata(saved_rdata)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
// Bench for banked_regfile: seeded random steps plus directed cases,
// checked against a per-bank model held in the bench.
module banked_regfile_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = '0;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, cur_we = 1'b0, saved_we = 1'b0;
    logic [DW-1:0] cur_wdata = '0, cur_st, saved_wdata = '0, saved_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    banked_regfile #(.DATA_W(DW)) u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_st(cur_st),
        .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata)
    );

    // Model: user set incl. pc at [15], fast bank, four private pairs, saved words
    logic [DW-1:0] m_usr [16];
    logic [DW-1:0] m_fast [7];
    logic [DW-1:0] m_pair [4][2];
    logic [DW-1:0] m_saved [5];
    logic [DW-1:0] m_cur;

    function automatic logic [DW-1:0] model_rd(logic [2:0] m, logic [3:0] i);
        if (m == 3'd1 && i >= 4'd8 && i <= 4'd14) return m_fast[i - 4'd8];
        if (m >= 3'd2 && m <= 3'd5 && (i == 4'd13 || i == 4'd14))
            return m_pair[m - 3'd2][i - 4'd13];
        return m_usr[i];
    endfunction

    function automatic logic [DW-1:0] model_saved(logic [2:0] m);
        if (m >= 3'd1 && m <= 3'd5) return m_saved[m - 3'd1];
        return '0;
    endfunction

    function automatic string tag_of(logic [2:0] m, logic [3:0] i);
        if (i == 4'd15) return "R5";
        if (m == 3'd1 && i >= 4'd8) return "R3";
        if (m >= 3'd2 && m <= 3'd5 && i >= 4'd13) return "R4";
        return "R2";
    endfunction

    task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare every output with the model (inputs already settled)
    task automatic compare_all();
        check(tag_of(mode, rd_a_idx), rd_a_data, model_rd(mode, rd_a_idx));
        check("R9", rd_b_data, model_rd(mode, rd_b_idx));
        check(saved_model_tag(mode), saved_rdata, model_saved(mode));
        check("R10", cur_st, m_cur);
    endtask

    function automatic string saved_model_tag(logic [2:0] m);
        return (m >= 3'd1 && m <= 3'd5) ? "R6" : "R7";
    endfunction

    // One cycle: check outputs before the edge, then apply writes to model
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        if (wr_en) begin
            if (mode == 3'd1 && wr_idx >= 4'd8 && wr_idx <= 4'd14) m_fast[wr_idx - 4'd8] = wr_data;
            else if (mode >= 3'd2 && mode <= 3'd5 && (wr_idx == 4'd13 || wr_idx == 4'd14))
                m_pair[mode - 3'd2][wr_idx - 4'd13] = wr_data;
            else m_usr[wr_idx] = wr_data;
        end
        if (saved_we && mode >= 3'd1 && mode <= 3'd5) m_saved[mode - 3'd1] = saved_wdata;
        if (cur_we) m_cur = cur_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; cur_we = 1'b0; saved_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0B4C));
        for (int i = 0; i < 16; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++) m_fast[i] = '0;
        for (int i = 0; i < 4; i++) begin m_pair[i][0] = '0; m_pair[i][1] = '0; end
        for (int i = 0; i < 5; i++) m_saved[i] = '0;
        m_cur = 32'h3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through every mode and index
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            for (int i = 0; i < 16; i++) begin
                rd_a_idx = 4'(i);
                #1 check("R1", rd_a_data, '0);
            end
            check("R1", saved_rdata, '0);
        end
        check("R1", cur_st, 32'h3);
        @(negedge clk);

        // R3: fast-bank write to r8 leaves the User r8 alone
        mode = 3'd1; wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'hF1F1_0008;
        rd_a_idx = 4'd8; rd_b_idx = 4'd8;
        step(); idle();
        mode = 3'd0; rd_a_idx = 4'd8; #1 check("R3", rd_a_data, '0);
        mode = 3'd1; #1 check("R3", rd_a_data, 32'hF1F1_0008);
        @(negedge clk);

        // R4: r13 in interrupt mode is separate from r13 in supervisor mode
        mode = 3'd2; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1111_0013;
        step(); idle();
        mode = 3'd3; rd_a_idx = 4'd13; #1 check("R4", rd_a_data, '0);
        mode = 3'd2; #1 check("R4", rd_a_data, 32'h1111_0013);
        @(negedge clk);

        // R8: read of the word being written returns the old value
        mode = 3'd5; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hAAAA_5555;
        rd_a_idx = 4'd14;
        #1 check("R8", rd_a_data, '0);
        @(posedge clk); m_pair[3][1] = 32'hAAAA_5555; @(negedge clk); idle();
        #1 check("R8", rd_a_data, 32'hAAAA_5555);
        @(negedge clk);

        // R7: saved-status write in User mode leaves every saved word at zero
        mode = 3'd0; saved_we = 1'b1; saved_wdata = 32'hDEAD_BEEF;
        step(); idle();
        for (int m = 1; m <= 5; m++) begin
            mode = 3'(m); #1 check("R7", saved_rdata, '0);
        end
        mode = 3'd6; #1 check("R7", saved_rdata, '0);
        @(negedge clk);

        // R6: a saved write in abort mode lands only in the abort word
        mode = 3'd4; saved_we = 1'b1; saved_wdata = 32'h0AB0_0004;
        step(); idle();
        mode = 3'd4; #1 check("R6", saved_rdata, 32'h0AB0_0004);
        mode = 3'd5; #1 check("R6", saved_rdata, '0);
        @(negedge clk);

        // R11: writes disabled, random data and index must not land
        mode = 3'd0; wr_en = 1'b0; wr_idx = 4'd3; wr_data = 32'h1234_5678;
        rd_a_idx = 4'd3;
        step();
        #1 check("R11", rd_a_data, '0);

        // Random mix of modes, indices and writes
        for (int n = 0; n < 3000; n++) begin
            mode        = 3'($urandom % 8);
            rd_a_idx    = 4'($urandom % 16);
            rd_b_idx    = 4'($urandom % 16);
            wr_idx      = 4'($urandom % 16);
            wr_en       = ($urandom % 4) != 0;
            wr_data     = $urandom;
            saved_we    = ($urandom % 3) == 0;
            saved_wdata = $urandom;
            cur_we      = ($urandom % 5) == 0;
            cur_wdata   = $urandom;
            step();
        end
        idle();
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule